// File: doc/BRIEF.md
# Single-Carrier Dual-Compare PWM Generator

This block makes the raw comparison pulses for a two-stage AC-AC converter: a current-source rectifier stage followed by a three-leg voltage-source inverter stage. A free-running up/down counter forms one symmetric triangular carrier. The counter climbs from zero to a programmable peak and falls back to zero with equal, fixed slopes, so one sampling period lasts twice the peak count in clock cycles. The default peak of 7500 at a 150 MHz clock gives a 100 µs, 10 kHz period.

Software supplies seven compare values as plain integers: one for the rectifier pulse and two for each inverter leg. Each value is written into a shadow register. All shadow values move into the active registers together on the clock edge where the carrier returns to zero, so no threshold changes inside a period. Each output is high while the carrier lies below its active value. An inverter leg has two such pulses, which a later stage combines, so the inverter switches at twice the rate of the rectifier. The block also gives one-cycle strobes at the start of each period and at the carrier peak, and a synchronous enable stops the carrier and silences every output.

Top module: `tri_pwm_gen`

## Requirements
- R1: While enabled, the carrier output steps by exactly one per clock cycle: 0, 1, ..., PEAK, PEAK-1, ..., 1, 0, 1, and so on. One period is 2*PEAK cycles and the carrier never exceeds PEAK.
- R2: The rectifier pulse (compare channel select 0) is high exactly while the carrier is strictly below its active compare value.
- R3: Each inverter leg L (0..2) has two independent pulses. leg_pulse_p[L] follows compare channel select 1+2L and leg_pulse_q[L] follows select 2+2L, each high while the carrier is below that value. Select values of 7 and above write nothing.
- R4: An active compare value of 0 holds its pulse low for the whole period. A value of PEAK or more holds it high for the whole period, including at the peak.
- R5: A write sets the shadow register of the selected channel on the next clock edge. Shadow values become active only on the edge where the carrier returns to zero, so a write made during a period has no effect on the pulses for the rest of that period.
- R6: period_start is high for exactly one cycle while the carrier is 0 and running. period_mid is high for exactly one cycle while the carrier is at PEAK, and the carrier is PEAK-1 in the next cycle.
- R7: One cycle after en falls, the carrier is 0 and every pulse and strobe is low for as long as en stays low. Active values follow the shadow values while disabled. After en rises again, the first cycle has carrier 0 with period_start high, and that first period uses the values written while disabled.
- R8: While rst is high, and in the cycle after it, the carrier is 0, all pulses and strobes are low, and all compare values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the carrier at 0 and outputs low |
| wr_en | input | 1 | Shadow compare write strobe |
| wr_sel | input | 3 | Channel select: 0 rectifier, 1+2L first and 2+2L second threshold of leg L |
| wr_data | input | CNT_W (13) | Compare value written to the selected shadow register |
| carrier | output | CNT_W (13) | Current triangular carrier count |
| rect_pulse | output | 1 | Rectifier comparison pulse |
| leg_pulse_p | output | LEGS (3) | First comparison pulse of each inverter leg |
| leg_pulse_q | output | LEGS (3) | Second comparison pulse of each inverter leg |
| period_start | output | 1 | One-cycle strobe at carrier 0 |
| period_mid | output | 1 | One-cycle strobe at carrier peak |

## Verification
A counter that steps wrongly or turns at the wrong count shows up at once on the carrier port. Its effect also reaches the strobes and the pulse edges, whose times are checked to the cycle within the first period. If shadow values reach the active registers too early, the pulse levels change after the mid-period write in the same period, within about a thousand cycles of that write. If they reach them too late, the new levels are missing at the next period start. A wrong selector decode or a wrong threshold test shows at the pulse edges near the programmed counts: 99 against 100, 2999 against 3000, the peak, and the values 0 and 1.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } tpg_dir_e;

    localparam int RECT_CHAN   = 0;
    localparam int CMP_PER_LEG = 2;

    function automatic int leg_chan(input int leg, input int half);
        return 1 + CMP_PER_LEG * leg + half;
    endfunction

    function automatic int chan_count(input int legs);
        return 1 + CMP_PER_LEG * legs;
    endfunction

endpackage

// File: rtl/tpg_carrier.sv
module tpg_carrier
    import tpg_pkg::*;
#(
    parameter int CNT_W = 13,
    parameter int PEAK  = 7500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             load_o,
    output logic             start_o,
    output logic             mid_o
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(PEAK);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    tpg_dir_e         dir_q, dir_nxt;
    logic             run_q;

    always_comb begin
        if (dir_q == DIR_UP) begin
            cnt_nxt = cnt_q + ONE;
            dir_nxt = (cnt_nxt == TOP) ? DIR_DOWN : DIR_UP;
        end else begin
            cnt_nxt = cnt_q - ONE;
            dir_nxt = (cnt_nxt == '0) ? DIR_UP : DIR_DOWN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (run_q) begin
                cnt_q <= cnt_nxt;
                dir_q <= dir_nxt;
            end
        end
    end

    assign cnt_o   = cnt_q;
    assign run_o   = run_q;
    assign load_o  = !run_q || (dir_q == DIR_DOWN && cnt_q == ONE);
    assign start_o = run_q && (cnt_q == '0);
    assign mid_o   = run_q && (cnt_q == TOP);

endmodule

// File: rtl/tpg_cmp_bank.sv
module tpg_cmp_bank #(
    parameter int CNT_W = 13,
    parameter int NCH   = 7,
    parameter int SEL_W = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [CNT_W-1:0]          wr_data,
    input  logic                      load,
    output logic [NCH-1:0][CNT_W-1:0] act_o
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [CNT_W-1:0] shadow_q;
        logic [CNT_W-1:0] active_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q <= '0;
            end else if (wr_en && wr_sel == SEL_W'(i)) begin
                shadow_q <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                active_q <= '0;
            end else if (load) begin
                active_q <= shadow_q;
            end
        end

        assign act_o[i] = active_q;
    end

endmodule

// File: rtl/tpg_compare.sv
module tpg_compare #(
    parameter int CNT_W = 13,
    parameter int PEAK  = 7500,
    parameter int NCH   = 7
) (
    input  logic                      run,
    input  logic [CNT_W-1:0]          cnt,
    input  logic [NCH-1:0][CNT_W-1:0] act,
    output logic [NCH-1:0]            pulse_o
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(PEAK);

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        logic full_on;
        logic below;
        assign full_on    = (act[i] >= TOP);
        assign below      = (cnt < act[i]);
        assign pulse_o[i] = run && (full_on || below);
    end

endmodule

// File: rtl/tri_pwm_gen.sv
module tri_pwm_gen
    import tpg_pkg::*;
#(
    parameter int CNT_W = 13,
    parameter int PEAK  = 7500,
    parameter int LEGS  = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             en,
    input  logic                             wr_en,
    input  logic [$clog2(2*LEGS+1)-1:0]      wr_sel,
    input  logic [CNT_W-1:0]                 wr_data,
    output logic [CNT_W-1:0]                 carrier,
    output logic                             rect_pulse,
    output logic [LEGS-1:0]                  leg_pulse_p,
    output logic [LEGS-1:0]                  leg_pulse_q,
    output logic                             period_start,
    output logic                             period_mid
);
    localparam int NCH   = chan_count(LEGS);
    localparam int SEL_W = $clog2(NCH);

    logic                      run;
    logic                      load;
    logic [NCH-1:0][CNT_W-1:0] act;
    logic [NCH-1:0]            pulse;

    tpg_carrier #(.CNT_W(CNT_W), .PEAK(PEAK)) u_carrier (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .cnt_o  (carrier),
        .run_o  (run),
        .load_o (load),
        .start_o(period_start),
        .mid_o  (period_mid)
    );

    tpg_cmp_bank #(.CNT_W(CNT_W), .NCH(NCH), .SEL_W(SEL_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .load   (load),
        .act_o  (act)
    );

    tpg_compare #(.CNT_W(CNT_W), .PEAK(PEAK), .NCH(NCH)) u_cmp (
        .run    (run),
        .cnt    (carrier),
        .act    (act),
        .pulse_o(pulse)
    );

    assign rect_pulse = pulse[RECT_CHAN];

    for (genvar l = 0; l < LEGS; l++) begin : g_leg
        assign leg_pulse_p[l] = pulse[leg_chan(l, 0)];
        assign leg_pulse_q[l] = pulse[leg_chan(l, 1)];
    end

endmodule

// File: rtl/tri_pwm_gen_chk.sv
module tri_pwm_gen_chk #(
    parameter int CNT_W = 13,
    parameter int PEAK  = 7500,
    parameter int NCH   = 7
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      en,
    input logic                      run,
    input logic [CNT_W-1:0]          cnt,
    input logic                      start,
    input logic                      mid,
    input logic [NCH-1:0][CNT_W-1:0] act,
    input logic [NCH-1:0]            pulses
);
    localparam logic [CNT_W-1:0] TOP  = CNT_W'(PEAK);
    localparam logic [CNT_W-1:0] TOPM = CNT_W'(PEAK - 1);

    assert_step_R1: assert property (@(posedge clk) disable iff (rst)
        (run && en) |=> (!en || cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

    assert_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP);

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $stable(act));

    assert_start_single_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    assert_mid_turn_R6: assert property (@(posedge clk) disable iff (rst)
        (mid && en) |=> (cnt == TOPM && !mid));

    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pulses == '0 && cnt == '0 && !start && !mid));

endmodule

bind tri_pwm_gen tri_pwm_gen_chk #(.CNT_W(CNT_W), .PEAK(PEAK), .NCH(NCH)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .run   (run),
    .cnt   (carrier),
    .start (period_start),
    .mid   (period_mid),
    .act   (act),
    .pulses(pulse)
);

// File: tb/tri_pwm_gen_bench.sv
module tri_pwm_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 7500;
    localparam int NC = 7;

    typedef int cmp_t[NC];

    typedef struct {
        int    cyc;
        int    cnt;
        int    pul;
        bit    st;
        bit    md;
        string req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [12:0] wr_data = '0;
    logic [12:0] carrier;
    logic        rect_pulse;
    logic [2:0]  leg_pulse_p, leg_pulse_q;
    logic        period_start, period_mid;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    item_t q[$];

    tri_pwm_gen u_tri_pwm_gen (
        .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .carrier(carrier), .rect_pulse(rect_pulse),
        .leg_pulse_p(leg_pulse_p), .leg_pulse_q(leg_pulse_q),
        .period_start(period_start), .period_mid(period_mid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int tri_at(int s);
        int ph;
        ph = s % (2 * P);
        return (ph <= P) ? ph : 2 * P - ph;
    endfunction

    function automatic int pulses_for(int c, cmp_t cmp);
        int v;
        v = 0;
        for (int i = 0; i < NC; i++)
            if (cmp[i] >= P || c < cmp[i]) v = v | (1 << i);
        return v;
    endfunction

    task automatic push(int base, int s, cmp_t cmp, string req);
        item_t it;
        it.cyc = base + s;
        it.cnt = tri_at(s);
        it.pul = pulses_for(it.cnt, cmp);
        it.st  = (it.cnt == 0);
        it.md  = (it.cnt == P);
        it.req = req;
        q.push_back(it);
    endtask

    task automatic push_idle(int c, string req);
        item_t it;
        it.cyc = c; it.cnt = 0; it.pul = 0; it.st = 0; it.md = 0; it.req = req;
        q.push_back(it);
    endtask

    task automatic wr(int sel, int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 13'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic finish_run();
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R1 pending items act=%0d exp=0", q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // monitor: pops expected items when their cycle comes up
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                item_t it;
                int ap;
                it = q.pop_front();
                ap = 0;
                ap = ap | int'(rect_pulse);
                for (int l = 0; l < 3; l++) begin
                    ap = ap | (int'(leg_pulse_p[l]) << (1 + 2 * l));
                    ap = ap | (int'(leg_pulse_q[l]) << (2 + 2 * l));
                end
                checks++;
                if (it.cyc != cyc || int'(carrier) != it.cnt || ap != it.pul ||
                    period_start != it.st || period_mid != it.md) begin
                    fails++;
                    $display("FAIL %s cyc=%0d/%0d carrier act=%0d exp=%0d pulses act=%b exp=%b start act=%b exp=%b mid act=%b exp=%b",
                             it.req, cyc, it.cyc, carrier, it.cnt, 7'(ap), 7'(it.pul),
                             period_start, it.st, period_mid, it.md);
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            finish_run();
        end
    end

    initial begin
        cmp_t c0, c1, c2;
        int base, base2, m;
        c0 = '{3000, 100, 7500, 0, 3750, 8000, 6000};
        c1 = '{1000, 7000, 0, 7600, 2000, 1, 5000};
        c2 = c1;
        c2[0] = 5;

        repeat (3) @(negedge clk);
        push_idle(cyc + 1, "R8");
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        push_idle(cyc + 1, "R8");
        @(negedge clk);

        // program while disabled (also R3 select decode, select 7 writes nothing)
        for (int i = 0; i < NC; i++) wr(i, c0[i]);
        wr(7, 1234);
        @(negedge clk);

        en = 1'b1;
        base = cyc + 1;
        push(base, 0, c0, "R6");
        push(base, 1, c0, "R1");
        push(base, 99, c0, "R3");
        push(base, 100, c0, "R3");
        push(base, 2999, c0, "R2");
        push(base, 3000, c0, "R2");
        push(base, 3749, c0, "R3");
        push(base, 3750, c0, "R3");
        push(base, P - 1, c0, "R6");
        push(base, P, c0, "R4");
        push(base, P + 1, c0, "R1");
        push(base, 2 * P - 3000, c0, "R2");
        push(base, 2 * P - 2999, c0, "R2");
        push(base, 8000, c0, "R5");
        push(base, 2 * P - 50, c0, "R5");
        push(base, 2 * P - 1, c0, "R5");
        push(base, 2 * P, c1, "R4");
        push(base, 2 * P + 1, c1, "R4");
        push(base, 2 * P + 1999, c1, "R3");
        push(base, 2 * P + 2000, c1, "R3");
        q.sort() with (item.cyc);

        wait_until(base + 6000);
        for (int i = 0; i < NC; i++) wr(i, c1[i]);

        wait_until(base + 2 * P + 2010);
        en = 1'b0;
        m = cyc;
        push_idle(m + 1, "R7");
        push_idle(m + 5, "R7");
        wr(0, 5);
        wait_until(m + 8);

        en = 1'b1;
        base2 = cyc + 1;
        push(base2, 0, c2, "R7");
        push(base2, 4, c2, "R7");
        push(base2, 5, c2, "R7");
        wait_until(base2 + 10);

        done = 1;
        finish_run();
    end

endmodule